// File: doc/BRIEF.md
# Lane Load Coalescer with Line Replay

This block takes one load issued on behalf of a group of 32 lanes and turns it into a short series of cache-line passes. Each active lane carries a byte address and an access size. On every pass the block picks one 128-byte line, gathers every pending lane that points into it, and looks that line up in a small direct-mapped tag store.

On a hit, the gathered lanes get their bytes back in one response beat. On a miss, the block asks a next-level memory port for the whole line. When the fill arrives, the line is installed and the same pass runs again, now as a hit. Lanes that were not in the chosen line stay pending and are replayed on later passes, until none are left.

A new load is taken only while the block is idle. The requester sees this through a ready signal. The final beat of a load carries a done flag.

Top module: `warp_load_coalescer`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle that carries the final beat of that request.
- R2: Each pass serves the line addressed by the lowest-numbered lane still pending, where the line address is addr[31:7]. The beat's `rsp_mask` holds exactly the pending lanes whose line address matches it.
- R3: Lanes with identical or overlapping addresses in one line are all served in the same beat, with no extra pass.
- R4: Lane i's result sits in `rsp_data[32*i+31:32*i]`. The result is read little-endian from its byte offset addr[6:0] in the line and zero-extended. The size code gives the width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Accesses are naturally aligned. Slots of lanes not in `rsp_mask` read zero.
- R5: On a hit, no fill is requested. Consecutive hit passes put out one beat per clock.
- R6: On a miss, `fill_req_valid` pulses for one cycle with the line address on `fill_req_line`. The line returned on `fill_rsp_valid`/`fill_rsp_data` (byte b at bits 8b+7:8b) is installed, and the same lane group is then served from it.
- R7: The tag store is direct-mapped with 32 entries indexed by line address bits [4:0]. A line that maps to an occupied index evicts the entry there, so the evicted line misses again.
- R8: Every active lane is served exactly once per request. Inactive lanes never appear in `rsp_mask`.
- R9: `rsp_done` is high only on the final beat. A request with an empty lane mask yields one beat with a zero mask and `rsp_done` high, and no fill.
- R10: After reset `req_ready` is high, `rsp_valid` and `fill_req_valid` are low, and the tag store holds no valid lines, so the first access to any line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mask | input | 32 | Active lanes of the request |
| req_addr | input | 1024 | Byte address per lane, lane i at bits 32i+31:32i |
| req_size | input | 64 | Size code per lane, lane i at bits 2i+1:2i |
| rsp_valid | output | 1 | Response beat present |
| rsp_mask | output | 32 | Lanes served by this beat |
| rsp_data | output | 1024 | Per-lane results, lane i at bits 32i+31:32i |
| rsp_done | output | 1 | Final beat of the request |
| fill_req_valid | output | 1 | One-cycle line fill request |
| fill_req_line | output | 25 | Line address of the fill |
| fill_rsp_valid | input | 1 | Fill data present |
| fill_rsp_data | input | 1024 | Whole line returned by the next level |

## Verification
On every cycle, the bound checker enforces the handshake and bookkeeping rules:
- no new request is taken while a load is in flight;
- fill requests are single-cycle and occur only while busy;
- each beat's lanes lie within the accepted mask and have not been served before;
- the done beat completes exactly the accepted mask;
- an empty beat always ends the request.

Which lanes group together, the order of passes, byte extraction and size masking, hit-versus-miss fill counts, and eviction between lines of the same index depend on address contents. Only the directed scenarios show these, by comparing each beat against a reference model of the lines and the tag store kept in the bench.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_FILL   = 2'd2
   } wlc_state_e;

   // Byte-enable mask for a lane result from its size code.
   function automatic logic [31:0] size_keep(input logic [1:0] sz);
      case (sz)
         2'd0:    size_keep = 32'h0000_00FF;
         2'd1:    size_keep = 32'h0000_FFFF;
         default: size_keep = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/wlc_pick.sv
// Chooses the line of the lowest pending lane and gathers its group.
module wlc_pick #(
   parameter int LANES = 32,
   parameter int LA_W  = 25
) (
   input  logic [LANES-1:0]      pending,
   input  logic [LANES*LA_W-1:0] lane_lines,
   output logic                  any_pending,
   output logic [LA_W-1:0]       lead_line,
   output logic [LANES-1:0]      group
);

   always_comb begin
      logic found;
      found     = 1'b0;
      lead_line = '0;
      for (int i = 0; i < LANES; i++) begin
         if (pending[i] && !found) begin
            found     = 1'b1;
            lead_line = lane_lines[i*LA_W +: LA_W];
         end
      end
      any_pending = found;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_match
      assign group[g] = pending[g] && (lane_lines[g*LA_W +: LA_W] == lead_line);
   end

endmodule

// File: rtl/wlc_tag_store.sv
// Direct-mapped tag and line store, combinational lookup, fill write.
module wlc_tag_store #(
   parameter int NUM_LINES = 32,
   parameter int LA_W      = 25,
   parameter int LINE_W    = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LA_W-1:0]   lk_line,
   output logic              hit,
   output logic [LINE_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [LA_W-1:0]   wr_line,
   input  logic [LINE_W-1:0] wr_data
);

   localparam int IDX_W = $clog2(NUM_LINES);
   localparam int TAG_W = LA_W - IDX_W;

   initial begin : p_elab
      assert (NUM_LINES >= 2 && (NUM_LINES & (NUM_LINES - 1)) == 0)
         else $error("NUM_LINES must be a power of two of at least 2");
      assert (TAG_W >= 1) else $error("line address too narrow for index");
   end

   logic [NUM_LINES-1:0] vld_q;
   logic [TAG_W-1:0]     tag_q  [NUM_LINES];
   logic [LINE_W-1:0]    line_q [NUM_LINES];

   logic [IDX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0] lk_tag, wr_tag;

   assign lk_idx  = lk_line[IDX_W-1:0];
   assign lk_tag  = lk_line[LA_W-1:IDX_W];
   assign wr_idx  = wr_line[IDX_W-1:0];
   assign wr_tag  = wr_line[LA_W-1:IDX_W];
   assign hit     = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign rd_data = line_q[lk_idx];

   always_ff @(posedge clk) begin
      if (!rst_n)     vld_q         <= '0;
      else if (wr_en) vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_data;
      end
   end

endmodule

// File: rtl/wlc_lane_extract.sv
// Per-lane byte extraction and zero extension from one line.
module wlc_lane_extract
   import wlc_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int OFF_W  = 7,
   parameter int LINE_W = 1024
) (
   input  logic [LINE_W-1:0]      line_data,
   input  logic [LANES*OFF_W-1:0] offs,
   input  logic [LANES*2-1:0]     sizes,
   input  logic [LANES-1:0]       sel,
   output logic [LANES*32-1:0]    lane_data
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [31:0] raw;
      for (genvar k = 0; k < 4; k++) begin : g_byte
         logic [OFF_W-1:0] bo;
         assign bo            = offs[l*OFF_W +: OFF_W] + OFF_W'(k);
         assign raw[k*8 +: 8] = line_data[{bo, 3'b000} +: 8];
      end
      assign lane_data[l*32 +: 32] = sel[l] ? (raw & size_keep(sizes[l*2 +: 2])) : 32'h0;
   end

endmodule

// File: rtl/warp_load_coalescer.sv
module warp_load_coalescer
   import wlc_pkg::*;
#(
   parameter int LANES      = 32,
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 128,
   parameter int NUM_LINES  = 32,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LA_W      = ADDR_W - OFF_W,
   localparam int LINE_W    = LINE_BYTES * 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES-1:0]        req_mask,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES*2-1:0]      req_size,
   output logic                    rsp_valid,
   output logic [LANES-1:0]        rsp_mask,
   output logic [LANES*32-1:0]     rsp_data,
   output logic                    rsp_done,
   output logic                    fill_req_valid,
   output logic [LA_W-1:0]         fill_req_line,
   input  logic                    fill_rsp_valid,
   input  logic [LINE_W-1:0]       fill_rsp_data
);

   initial begin : p_elab
      assert (LINE_BYTES >= 4 && (LINE_BYTES & (LINE_BYTES - 1)) == 0)
         else $error("LINE_BYTES must be a power of two of at least 4");
      assert (LANES >= 1) else $error("LANES must be positive");
   end

   wlc_state_e                state_q;
   logic [LANES-1:0]          pend_q;
   logic [LANES*ADDR_W-1:0]   addr_q;
   logic [LANES*2-1:0]        size_q;

   logic [LANES*LA_W-1:0]     lane_lines;
   logic [LANES*OFF_W-1:0]    lane_offs;
   logic                      any_pend;
   logic [LA_W-1:0]           lead_line;
   logic [LANES-1:0]          grp;
   logic                      hit;
   logic [LINE_W-1:0]         rd_line;
   logic [LANES*32-1:0]       lane_data;
   logic                      fill_wr;
   logic [LANES-1:0]          left;

   for (genvar l = 0; l < LANES; l++) begin : g_split
      assign lane_lines[l*LA_W +: LA_W]  = addr_q[l*ADDR_W + OFF_W +: LA_W];
      assign lane_offs[l*OFF_W +: OFF_W] = addr_q[l*ADDR_W +: OFF_W];
   end

   assign req_ready = (state_q == ST_IDLE);
   assign fill_wr   = (state_q == ST_FILL) && fill_rsp_valid;
   assign left      = pend_q & ~grp;

   wlc_pick #(.LANES(LANES), .LA_W(LA_W)) u_pick (
      .pending     (pend_q),
      .lane_lines  (lane_lines),
      .any_pending (any_pend),
      .lead_line   (lead_line),
      .group       (grp)
   );

   wlc_tag_store #(.NUM_LINES(NUM_LINES), .LA_W(LA_W), .LINE_W(LINE_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_line (lead_line),
      .hit     (hit),
      .rd_data (rd_line),
      .wr_en   (fill_wr),
      .wr_line (fill_req_line),
      .wr_data (fill_rsp_data)
   );

   wlc_lane_extract #(.LANES(LANES), .OFF_W(OFF_W), .LINE_W(LINE_W)) u_extract (
      .line_data (rd_line),
      .offs      (lane_offs),
      .sizes     (size_q),
      .sel       (grp),
      .lane_data (lane_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q        <= ST_IDLE;
         pend_q         <= '0;
         addr_q         <= '0;
         size_q         <= '0;
         rsp_valid      <= 1'b0;
         rsp_mask       <= '0;
         rsp_data       <= '0;
         rsp_done       <= 1'b0;
         fill_req_valid <= 1'b0;
         fill_req_line  <= '0;
      end else begin
         rsp_valid      <= 1'b0;
         rsp_done       <= 1'b0;
         fill_req_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  size_q  <= req_size;
                  pend_q  <= req_mask;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (!any_pend) begin
                  rsp_valid <= 1'b1;
                  rsp_mask  <= '0;
                  rsp_data  <= '0;
                  rsp_done  <= 1'b1;
                  state_q   <= ST_IDLE;
               end else if (hit) begin
                  rsp_valid <= 1'b1;
                  rsp_mask  <= grp;
                  rsp_data  <= lane_data;
                  pend_q    <= left;
                  if (left == '0) begin
                     rsp_done <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
               end else begin
                  fill_req_valid <= 1'b1;
                  fill_req_line  <= lead_line;
                  state_q        <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (fill_rsp_valid) state_q <= ST_LOOKUP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/warp_load_coalescer_chk.sv
module warp_load_coalescer_chk #(
   parameter int LANES = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [LANES-1:0] req_mask,
   input logic             rsp_valid,
   input logic [LANES-1:0] rsp_mask,
   input logic             rsp_done,
   input logic             fill_req_valid
);

   logic [LANES-1:0] want_q;
   logic [LANES-1:0] served_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         want_q   <= '0;
         served_q <= '0;
      end else if (req_valid && req_ready) begin
         want_q   <= req_mask;
         served_q <= '0;
      end else if (rsp_valid) begin
         served_q <= rsp_done ? '0 : (served_q | rsp_mask);
      end
   end

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);                          // R1
   AST_FILL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |-> !req_ready);                                 // R1
   AST_FILL_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req_valid |=> !fill_req_valid);                            // R6
   AST_LANES_IN_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_mask & ~want_q) == '0);                      // R8
   AST_NO_LANE_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_mask & served_q) == '0);                     // R8
   AST_DONE_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (served_q | rsp_mask) == want_q);                  // R8
   AST_DONE_WITH_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> rsp_valid);                                        // R9
   AST_EMPTY_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_mask == '0 |-> rsp_done);                      // R9

endmodule

bind warp_load_coalescer warp_load_coalescer_chk #(.LANES(LANES)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_mask       (req_mask),
   .rsp_valid      (rsp_valid),
   .rsp_mask       (rsp_mask),
   .rsp_done       (rsp_done),
   .fill_req_valid (fill_req_valid)
);

// File: tb/warp_load_coalescer_tb.sv
`timescale 1ns/1ps
module warp_load_coalescer_tb;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [31:0]   req_mask = '0;
   logic [1023:0] req_addr = '0;
   logic [63:0]   req_size = '0;
   logic          rsp_valid;
   logic [31:0]   rsp_mask;
   logic [1023:0] rsp_data;
   logic          rsp_done;
   logic          fill_req_valid;
   logic [24:0]   fill_req_line;
   logic          fill_rsp_valid = 1'b0;
   logic [1023:0] fill_rsp_data = '0;

   int vecs = 0;
   int errs = 0;
   int fill_cnt = 0;
   logic [24:0] last_fill = '0;

   logic [31:0] t_addr [32];
   logic [1:0]  t_size [32];
   logic [31:0] t_mask;

   logic        mv [32];
   logic [24:0] ml [32];

   always #2 clk = ~clk;

   warp_load_coalescer u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mask(req_mask), .req_addr(req_addr), .req_size(req_size),
      .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_data(rsp_data),
      .rsp_done(rsp_done), .fill_req_valid(fill_req_valid),
      .fill_req_line(fill_req_line), .fill_rsp_valid(fill_rsp_valid),
      .fill_rsp_data(fill_rsp_data)
   );

   function automatic logic [7:0] mb(input logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
   endfunction

   function automatic logic [31:0] exp_lane(input logic [31:0] a, input logic [1:0] s);
      logic [31:0] r = '0;
      int n = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
      for (int k = 0; k < n; k++) r[k*8 +: 8] = mb(a + 32'(k));
      return r;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Next-level memory model: answers each fill three cycles later.
   initial begin
      forever begin
         @(negedge clk);
         if (fill_req_valid) begin
            logic [24:0] ln;
            ln = fill_req_line;
            fill_cnt++;
            last_fill = ln;
            repeat (3) @(negedge clk);
            for (int b = 0; b < 128; b++) fill_rsp_data[b*8 +: 8] = mb({ln, 7'b0} + 32'(b));
            fill_rsp_valid = 1'b1;
            @(negedge clk);
            fill_rsp_valid = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   // Drives t_* as one request and checks every beat against the model.
   task automatic run_req(input string mtag);
      logic [31:0] pend;
      logic        exp_done;
      pend = t_mask;
      while (!req_ready) @(negedge clk);
      for (int i = 0; i < 32; i++) begin
         req_addr[i*32 +: 32] = t_addr[i];
         req_size[i*2 +: 2]   = t_size[i];
      end
      req_mask  = t_mask;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 ready low while busy", 64'(req_ready), 64'(0));
      do begin
         logic [31:0] grp;
         logic [24:0] ln;
         logic        fnd, miss;
         int          f0, w;
         grp = '0; ln = '0; fnd = 1'b0; miss = 1'b0;
         for (int i = 0; i < 32; i++)
            if (pend[i] && !fnd) begin fnd = 1'b1; ln = t_addr[i][31:7]; end
         for (int i = 0; i < 32; i++)
            if (pend[i] && t_addr[i][31:7] == ln) grp[i] = 1'b1;
         if (fnd) begin
            miss = !(mv[ln[4:0]] && ml[ln[4:0]] == ln);
            mv[ln[4:0]] = 1'b1;
            ml[ln[4:0]] = ln;
         end
         exp_done = ((pend & ~grp) == 0);
         f0 = fill_cnt;
         w = 0;
         do begin @(negedge clk); w++; end while (!rsp_valid && w < 200);
         if (!rsp_valid) begin
            chk("R2 beat arrives", 64'(0), 64'(1));
            return;
         end
         chk(mtag, 64'(rsp_mask), 64'(grp));
         chk("R9 done flag", 64'(rsp_done), 64'(exp_done));
         for (int i = 0; i < 32; i++)
            chk(grp[i] ? "R4 lane data" : "R4 unserved slot zero",
                64'(rsp_data[i*32 +: 32]),
                64'(grp[i] ? exp_lane(t_addr[i], t_size[i]) : 32'h0));
         if (!fnd) begin
            chk("R9 empty request no fill", 64'(fill_cnt), 64'(f0));
         end else if (miss) begin
            chk("R6 one fill on miss", 64'(fill_cnt), 64'(f0 + 1));
            chk("R6 fill line address", 64'(last_fill), 64'(ln));
         end else begin
            chk("R5 no fill on hit", 64'(fill_cnt), 64'(f0));
            chk("R5 hit beat next cycle", 64'(w), 64'(1));
         end
         pend = pend & ~grp;
      end while (!exp_done);
      chk("R1 ready after final beat", 64'(req_ready), 64'(1));
   endtask

   task automatic clear_req();
      for (int i = 0; i < 32; i++) begin t_addr[i] = '0; t_size[i] = 2'd2; end
      t_mask = '0;
   endtask

   task automatic test_reset();
      chk("R10 ready after reset", 64'(req_ready), 64'(1));
      chk("R10 no beat after reset", 64'(rsp_valid), 64'(0));
      chk("R10 no fill after reset", 64'(fill_req_valid), 64'(0));
   endtask

   task automatic test_broadcast();
      clear_req();
      for (int i = 0; i < 32; i++) t_addr[i] = 32'h1000_0040;
      t_mask = 32'hFFFF_FFFF;
      run_req("R3 broadcast same address one beat");
   endtask

   task automatic test_sizes();
      clear_req();
      for (int i = 0; i < 32; i++) begin
         t_size[i] = 2'(i % 4);
         t_addr[i] = (t_size[i] == 2'd0) ? 32'h2000_0000 + 32'(i * 3 + 1) :
                     (t_size[i] == 2'd1) ? 32'h2000_0040 + 32'(i * 2) :
                                           32'h2000_0000 + 32'(i * 4);
      end
      t_mask = 32'hFFFF_FFFF;
      run_req("R3 overlapping offsets share beat");
   endtask

   task automatic test_scatter();
      clear_req();
      for (int i = 0; i < 32; i++) t_addr[i] = 32'h3000_0000 + 32'(i * 128 + i * 4);
      t_mask = 32'hF0F0_FF0F;
      run_req("R2 scatter one lane per pass");
   endtask

   task automatic test_replay_hits();
      clear_req();
      for (int i = 0; i < 32; i++) t_addr[i] = 32'h3000_0000 + 32'(i * 128 + i * 4);
      t_mask = 32'hF0F0_FF0F;
      run_req("R5 replay all hits");
   endtask

   task automatic test_interleave();
      clear_req();
      for (int i = 0; i < 32; i++)
         t_addr[i] = (i % 2 == 0) ? 32'h4000_0000 + 32'(i * 4) : 32'h4000_0080 + 32'(i * 4);
      t_mask = 32'hFFFF_FFFE;
      run_req("R2 lowest pending lane picks line");
   endtask

   task automatic test_conflict();
      clear_req();
      t_addr[0] = {25'h040_0003, 7'h10};
      t_mask = 32'h1;
      run_req("R7 first line at index 3");
      t_addr[0] = {25'h080_0003, 7'h20};
      run_req("R7 second line evicts first");
      t_addr[0] = {25'h040_0003, 7'h10};
      run_req("R7 evicted line misses again");
      t_addr[5] = {25'h080_0003, 7'h04};
      t_mask = 32'h21;
      run_req("R7 two conflicting lines one request");
   endtask

   task automatic test_empty();
      clear_req();
      t_addr[3] = 32'h5000_0000;
      t_mask = 32'h0;
      run_req("R9 empty mask beat");
   endtask

   task automatic test_inactive();
      clear_req();
      for (int i = 0; i < 32; i++) t_addr[i] = 32'h6000_0000 + 32'((i % 4) * 128);
      t_mask = 32'h8421_1248;
      run_req("R8 only active lanes served");
   endtask

   initial begin
      for (int i = 0; i < 32; i++) begin mv[i] = 1'b0; ml[i] = '0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_broadcast();
      test_sizes();
      test_scatter();
      test_replay_hits();
      test_interleave();
      test_conflict();
      test_empty();
      test_inactive();
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule